// File: doc/BRIEF.md
# High-Address / General-Output Port

This block is an eight-pin output port that serves one of two owners, chosen by the chip's operating mode. In the two single-chip modes the pins are general-purpose outputs. They are driven from a data latch that software writes over the internal register bus. In the two expanded modes the same pins carry the upper byte of the CPU address on every bus cycle, and the latch is bypassed. A halt request can release all eight pins to high impedance. An option bit decides whether halt has that effect. High impedance is modelled as the per-pin output enable being deasserted.

Pin ownership is held in a three-state machine (`own_state_e`). In `OWN_LATCH` the latch drives the pins. In `OWN_ADDR` the address byte drives them. In `OWN_FLOAT` every enable is off and the data outputs are parked at zero. The state register updates on each rising clock edge from the mode strap and the halt inputs. The transitions are named as follows. `T_HALT` goes from any state to `OWN_FLOAT` while an effective halt is present. `T_RELEASE` goes from `OWN_FLOAT` to `OWN_LATCH` or `OWN_ADDR` once halt is gone. `T_TO_ADDR` goes from `OWN_LATCH` to `OWN_ADDR` when the strap selects an expanded mode. `T_TO_LATCH` goes from `OWN_ADDR` to `OWN_LATCH` when the strap selects a single-chip mode. Reset places the machine in `OWN_LATCH` with a cleared latch.

A register read never returns the latch. It returns the levels sensed at the pin drivers, after they pass through a synchronizer. A write always lands in the latch, whatever the mode. A value written in expanded mode therefore appears on the pins once the strap later selects a single-chip mode.

Top module: `hiaddr_port`

## Requirements
- R1: While reset is asserted and right after it, the port is in `OWN_LATCH` with a zero latch: `pin_oe` = 8'hFF, `pin_out` = 8'h00 and `bus_rdata` = 8'h00.
- R2: `mode_i[1]` = 1 selects an expanded mode (2'b10 normal expanded, 2'b11 test). After a clock edge that samples an expanded mode with no effective halt, `pin_oe` = 8'hFF, and `pin_out[i]` follows `cpu_addr_hi[i]`, which is address bit 8+i, in the same cycle.
- R3: `mode_i[1]` = 0 selects a single-chip mode (2'b00 normal, 2'b01 bootstrap). After a clock edge that samples a single-chip mode with no effective halt, `pin_oe` = 8'hFF and `pin_out` equals the latch.
- R4: A write (`bus_wr` = 1) with `bus_addr` equal to `PORT_OFFSET` (default 16'h1004) loads `bus_wdata` into the latch at that clock edge. A write to any other address leaves the latch unchanged.
- R5: A write accepted in an expanded mode is kept in the latch. It is driven on the pins after the strap selects a single-chip mode.
- R6: An effective halt (`halt_n_i` = 0 and `halt_keep_i` = 0) sampled at a clock edge moves the port to `OWN_FLOAT`. After that edge `pin_oe` = 8'h00 and `pin_out` = 8'h00.
- R7: With `halt_keep_i` = 1, a low `halt_n_i` has no effect, and the mode owner keeps `pin_oe` = 8'hFF.
- R8: When `bus_rd` = 1 and `bus_addr` = `PORT_OFFSET`, `bus_rdata` combinationally shows `pin_sense` as it was two clock edges earlier (two-stage synchronizer). In every other cycle `bus_rdata` = 8'h00.
- R9: After a clock edge that samples no effective halt, the port leaves `OWN_FLOAT` for the owner that the strap selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode strap; bit 1 set means expanded |
| halt_n_i | input | 1 | Active-low halt request |
| halt_keep_i | input | 1 | Option bit; when set, halt does not float the pins |
| cpu_addr_hi | input | DATA_W | CPU address bits 15..8 |
| bus_addr | input | REG_AW | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (sensed pin levels) |
| pin_sense | input | DATA_W | Levels sensed at the pin drivers |
| pin_out | output | DATA_W | Per-pin output data |
| pin_oe | output | DATA_W | Per-pin output enable |

## Verification
The bench builds the port with its defaults: eight pins, a 16-bit register bus decoding 16'h1004, and a two-stage synchronizer. At this width every byte of address, latch and sense data can occur, so random data reaches all bit positions. Decoding the real offset allows near-miss addresses such as 16'h1005 to be tried against the write path. The two-stage depth lets the readback latency be checked exactly against a reference that advances one stage per edge.

// File: rtl/hiaddr_port_pkg.sv
package hiaddr_port_pkg;

    typedef enum logic [1:0] {
        OWN_LATCH = 2'd0,
        OWN_ADDR  = 2'd1,
        OWN_FLOAT = 2'd2
    } own_state_e;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_BOOT   = 2'b01,
        MODE_EXPAND = 2'b10,
        MODE_TEST   = 2'b11
    } chip_mode_e;

    function automatic logic mode_is_expanded(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic logic halt_effective(input logic halt_n, input logic keep);
        return !halt_n && !keep;
    endfunction

endpackage

// File: rtl/hiaddr_pin_sync.sv
module hiaddr_pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hiaddr_regif.sv
module hiaddr_regif #(
    parameter int unsigned     W      = 8,
    parameter int unsigned     AW     = 16,
    parameter logic [AW-1:0]   OFFSET = 16'h1004
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  sense_sync,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  bus_rdata
);
    logic hit;
    assign hit = (bus_addr == OFFSET);

    // The latch accepts writes in every mode; ownership is decided downstream.
    always_ff @(posedge clk) begin
        if (!rst_n)            latch_q <= '0;
        else if (bus_wr && hit) latch_q <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) bus_rdata = sense_sync;
    end
endmodule

// File: rtl/hiaddr_own_fsm.sv
module hiaddr_own_fsm
    import hiaddr_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic        halt_n_i,
    input  logic        halt_keep_i,
    output own_state_e  state_o
);
    own_state_e state_q, state_d;
    logic       halt_req, expanded;

    assign halt_req = halt_effective(halt_n_i, halt_keep_i);
    assign expanded = mode_is_expanded(mode_i);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OWN_LATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_LATCH: begin
                if (halt_req)      state_d = OWN_FLOAT;   // T_HALT
                else if (expanded) state_d = OWN_ADDR;    // T_TO_ADDR
            end
            OWN_ADDR: begin
                if (halt_req)       state_d = OWN_FLOAT;  // T_HALT
                else if (!expanded) state_d = OWN_LATCH;  // T_TO_LATCH
            end
            OWN_FLOAT: begin
                if (!halt_req)                            // T_RELEASE
                    state_d = expanded ? OWN_ADDR : OWN_LATCH;
            end
            default: state_d = OWN_LATCH;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/hiaddr_pin_mux.sv
module hiaddr_pin_mux
    import hiaddr_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  own_state_e    state_i,
    input  logic [W-1:0]  latch_i,
    input  logic [W-1:0]  addr_hi_i,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe
);
    always_comb begin
        pin_out = '0;
        pin_oe  = '0;
        unique case (state_i)
            OWN_LATCH: begin
                pin_out = latch_i;
                pin_oe  = '1;
            end
            OWN_ADDR: begin
                pin_out = addr_hi_i;
                pin_oe  = '1;
            end
            OWN_FLOAT: begin
                pin_out = '0;
                pin_oe  = '0;
            end
            default: begin
                pin_out = '0;
                pin_oe  = '0;
            end
        endcase
    end
endmodule

// File: rtl/hiaddr_port.sv
module hiaddr_port
    import hiaddr_port_pkg::*;
#(
    parameter int unsigned         DATA_W      = 8,
    parameter int unsigned         REG_AW      = 16,
    parameter logic [REG_AW-1:0]   PORT_OFFSET = 16'h1004,
    parameter int unsigned         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              halt_n_i,
    input  logic              halt_keep_i,
    input  logic [DATA_W-1:0] cpu_addr_hi,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_sense,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);
    own_state_e        own_state;
    logic [DATA_W-1:0] sense_sync;
    logic [DATA_W-1:0] latch_q;

    hiaddr_pin_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_sense),
        .q     (sense_sync)
    );

    hiaddr_regif #(.W(DATA_W), .AW(REG_AW), .OFFSET(PORT_OFFSET)) i_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .sense_sync (sense_sync),
        .latch_q    (latch_q),
        .bus_rdata  (bus_rdata)
    );

    hiaddr_own_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .halt_n_i    (halt_n_i),
        .halt_keep_i (halt_keep_i),
        .state_o     (own_state)
    );

    hiaddr_pin_mux #(.W(DATA_W)) i_mux (
        .state_i   (own_state),
        .latch_i   (latch_q),
        .addr_hi_i (cpu_addr_hi),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );
endmodule

// File: rtl/hiaddr_port_chk.sv
module hiaddr_port_chk #(
    parameter int unsigned         DATA_W      = 8,
    parameter int unsigned         REG_AW      = 16,
    parameter logic [REG_AW-1:0]   PORT_OFFSET = 16'h1004,
    parameter int unsigned         SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              halt_n_i,
    input logic              halt_keep_i,
    input logic [DATA_W-1:0] cpu_addr_hi,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_sense,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe
);
    logic [1:0] age_q;
    logic       hit, halt_req;

    assign hit      = (bus_addr == PORT_OFFSET);
    assign halt_req = !halt_n_i && !halt_keep_i;

    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2
    addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $past(mode_i[1] && !halt_req)
        |-> (pin_oe == '1) && (pin_out == cpu_addr_hi));

    // R3
    latch_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $past(bus_wr && hit && !mode_i[1] && !halt_req)
        |-> (pin_oe == '1) && (pin_out == $past(bus_wdata)));

    // R6
    halt_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $past(halt_req)
        |-> (pin_oe == '0) && (pin_out == '0));

    // R7
    halt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $past(!halt_n_i && halt_keep_i)
        |-> (pin_oe == '1));

    // R8
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && hit) |-> (bus_rdata == '0));

    generate
        if (SYNC_STAGES == 2) begin : g_sync2
            // R8
            read_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) && bus_rd && hit
                |-> (bus_rdata == $past(pin_sense, 2)));
        end
    endgenerate
endmodule

bind hiaddr_port hiaddr_port_chk #(
    .DATA_W      (DATA_W),
    .REG_AW      (REG_AW),
    .PORT_OFFSET (PORT_OFFSET),
    .SYNC_STAGES (SYNC_STAGES)
) i_chk (.*);

// File: tb/test_hiaddr_port.sv
module test_hiaddr_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] OFFS = 16'h1004;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        halt_n_i, halt_keep_i;
    logic [7:0]  cpu_addr_hi;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata, pin_sense, pin_out, pin_oe;

    int n_checks = 0;
    int n_errors = 0;

    // reference model: 0 latch owner, 1 address owner, 2 floating
    int         m_state = 0;
    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_s1 = 8'h00, m_s2 = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiaddr_port i_hiaddr_port (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .halt_n_i(halt_n_i),
        .halt_keep_i(halt_keep_i), .cpu_addr_hi(cpu_addr_hi), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_sense(pin_sense), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic int next_owner(logic [1:0] m, logic hn, logic keep);
        if (!hn && !keep) return 2;
        return m[1] ? 1 : 0;
    endfunction

    function automatic logic [7:0] exp_out(int st, logic [7:0] latch, logic [7:0] ahi);
        if (st == 2) return 8'h00;
        return (st == 1) ? ahi : latch;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: inputs already driven; model advances at the edge, check at negedge
    task automatic cycle(string tag);
        string t;
        @(posedge clk);
        if (rst_n) begin
            m_s2 = m_s1;
            m_s1 = pin_sense;
            if (bus_wr && bus_addr == OFFS) m_latch = bus_wdata;
            m_state = next_owner(mode_i, halt_n_i, halt_keep_i);
        end
        @(negedge clk);
        t = tag;
        if (t == "") t = (m_state == 2) ? "R6" : (m_state == 1) ? "R2" : "R3";
        chk(t, pin_oe, (m_state == 2) ? 8'h00 : 8'hFF);
        chk(t, pin_out, exp_out(m_state, m_latch, cpu_addr_hi));
        chk("R8", bus_rdata, (bus_rd && bus_addr == OFFS) ? m_s2 : 8'h00);
    endtask

    task automatic idle_inputs();
        mode_i = 2'b00; halt_n_i = 1'b1; halt_keep_i = 1'b0;
        cpu_addr_hi = 8'h00; bus_addr = 16'h0000; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = 8'h00; pin_sense = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0;
        idle_inputs();
        pin_sense = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", pin_oe, 8'hFF);
        chk("R1", pin_out, 8'h00);
        chk("R1", bus_rdata, 8'h00);
        rst_n = 1'b1;
        pin_sense = 8'h00;
        cycle("R1");

        // R4: near-miss address ignored, then a hit
        bus_wr = 1'b1; bus_addr = OFFS + 16'd1; bus_wdata = 8'h77;
        cycle("R4");
        bus_addr = OFFS; bus_wdata = 8'hC3;
        cycle("R4");
        bus_wr = 1'b0;
        cycle("R4");

        // R5: write while expanded, retained for single-chip
        mode_i = 2'b11; cpu_addr_hi = 8'h3C; bus_wr = 1'b1; bus_addr = OFFS; bus_wdata = 8'hA5;
        cycle("R5");
        bus_wr = 1'b0; mode_i = 2'b01;
        cycle("R5");

        // R7: halt with keep bit set
        halt_n_i = 1'b0; halt_keep_i = 1'b1;
        cycle("R7");
        mode_i = 2'b10; cpu_addr_hi = 8'hE1;
        cycle("R7");

        // R6 then R9
        halt_keep_i = 1'b0;
        cycle("R6");
        halt_n_i = 1'b1;
        cycle("R9");
        halt_n_i = 1'b0;
        cycle("R6");
        halt_n_i = 1'b1; mode_i = 2'b00;
        cycle("R9");

        // R8: readback latency with a directed sense pattern
        bus_rd = 1'b1; bus_addr = OFFS; pin_sense = 8'h96;
        cycle("R8");
        pin_sense = 8'h21;
        cycle("R8");
        cycle("R8");
        cycle("R8");
        bus_rd = 1'b0;

        // constrained random
        for (int i = 0; i < 1500; i++) begin
            if (($urandom % 16) == 0) mode_i = 2'($urandom % 4);
            halt_n_i    = (($urandom % 8) != 0);
            halt_keep_i = (($urandom % 3) == 0);
            cpu_addr_hi = 8'($urandom);
            bus_addr    = (($urandom % 2) == 0) ? OFFS : 16'($urandom);
            bus_wr      = (($urandom % 3) == 0);
            bus_rd      = (($urandom % 2) == 0);
            bus_wdata   = 8'($urandom);
            pin_sense   = 8'($urandom);
            cycle("");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule